// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer

This block turns one PWM command into a pair of complementary gate enables for the two switches of a half-bridge. The high-side enable follows the command and the low-side enable follows its inverse. A break interval of a fixed number of clock cycles separates every hand-over from one switch to the other, so the two enables are never asserted together.

The block also applies three protective gates on top of the PWM command:
- An active-low shutdown input turns both enables off.
- Each supply domain reports a synchronous "supply good" flag. A bad low-side supply turns both enables off. A bad high-side supply turns off only the high-side enable.
- A single-cycle pulse from an external switch-node transient detector keeps the high side off for a programmable hold-off window.

The PWM command and the shutdown input are asynchronous, so each passes through a two-flop synchronizer. The supply flags and the transient pulse are already synchronous and are used as they arrive. When any blocking condition is released, the selected side waits one full break interval before it turns on.

Top module: `hb_gate_sequencer`

## Requirements
- R1: In steady operation with every protection released, `gate_hi` equals the synchronized `pwm_in` and `gate_lo` equals its inverse.
- R2: When the output changes from one side to the other, both enables stay low for exactly `DEAD_CYC` consecutive cycles. The incoming side then turns on.
- R3: `gate_hi` and `gate_lo` are never high in the same cycle, for any input sequence.
- R4: When `shdn_n` is low (0 = shut down), both enables are off. A change on the `shdn_n` pin reaches the outputs on the third rising edge after it.
- R5: When shutdown or an undervoltage is released, the side selected by `pwm_in` turns on only after `DEAD_CYC` cycles of both enables low.
  - After a supply flag returns to 1, the side turns on at the `DEAD_CYC`-th rising edge.
  - After `shdn_n` returns to 1, the side turns on at the (`DEAD_CYC`+2)-th rising edge.
- R6: When `lo_supply_ok` is 0 (1 = supply good), both enables turn off at the next rising edge.
- R7: When `hi_supply_ok` is 0, `gate_hi` turns off at the next rising edge. `gate_lo` keeps following the inverted command.
- R8: A 1 on `neg_tr_pulse` at a rising edge loads a hold-off timer of `HOLD_CYC` cycles.
  - `gate_hi` is off from the following edge while the timer runs.
  - A new pulse reloads the timer.
  - The high side returns `DEAD_CYC` cycles after the timer expires.
  - `gate_lo` is not affected.
- R9: Reset (active high, synchronous) drives both enables low and clears every timer. After reset, the first turn-on waits a full break interval.
- R10: A change on `pwm_in` reaches the outputs on the third rising edge after it: two synchronizer stages plus the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_in | input | 1 | Asynchronous PWM command; 1 selects the high side |
| shdn_n | input | 1 | Asynchronous shutdown, active low |
| lo_supply_ok | input | 1 | Low-side supply good flag (synchronous, 1 = good) |
| hi_supply_ok | input | 1 | High-side supply good flag (synchronous, 1 = good) |
| neg_tr_pulse | input | 1 | Qualified negative switch-node transient, one-cycle pulse |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |

## Verification
The hardest case to reach is a hold-off timer that is reloaded while it is already running. The second pulse must arrive before the first window ends, and the bench must show that the high side stays off past the point where the first window alone would have let it return. The stimulus first lets the high side settle on. It then sends one transient pulse, waits a few cycles, and sends a second pulse. It checks that `gate_hi` is still low one cycle after the first window plus the break interval would have ended, and that it comes back exactly one break interval after the second window.

A second hard case is a supply or shutdown release while the command is already steady. No PWM edge occurs, so the break interval must start from the release itself. The bench checks the turn-on cycle for each release source on its own.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;

    // Side requests derived from the command and the protections
    typedef struct packed {
        logic want_hi;
        logic want_lo;
    } gate_req_t;

    // Registered gate enable pair
    typedef struct packed {
        logic hi;
        logic lo;
    } gate_pair_t;

    // Conditions that may block one or both sides
    typedef struct packed {
        logic allow_lo;   // shutdown released and low-side supply good
        logic allow_hi;   // allow_lo plus high-side supply good, no hold-off
    } gate_allow_t;

    localparam gate_pair_t GATES_OFF = '{hi: 1'b0, lo: 1'b0};

    function automatic gate_allow_t f_allow(
        input logic run_n_ok,
        input logic lo_ok,
        input logic hi_ok,
        input logic hold_busy
    );
        gate_allow_t a;
        a.allow_lo = run_n_ok & lo_ok;
        a.allow_hi = a.allow_lo & hi_ok & ~hold_busy;
        return a;
    endfunction

    function automatic gate_req_t f_request(
        input logic        cmd,
        input gate_allow_t a
    );
        gate_req_t r;
        r.want_hi = cmd & a.allow_hi;
        r.want_lo = ~cmd & a.allow_lo;
        return r;
    endfunction

endpackage

// File: rtl/hb_sync_stage.sv
module hb_sync_stage #(
    parameter int          W      = 2,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] RST_V = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RST_V;
                    else     chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_V;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/hb_holdoff.sv
module hb_holdoff #(
    parameter int HOLD_CYC = 450
) (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    output logic busy
);
    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [HW-1:0] LOAD_V = HW'(HOLD_CYC);

    logic [HW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)                left_q <= '0;
        else if (hit)           left_q <= LOAD_V;
        else if (left_q != '0)  left_q <= left_q - 1'b1;
    end

    assign busy = (left_q != '0);

    AST_HOLD_LOAD:  assert property (@(posedge clk) disable iff (rst) hit |=> busy);                  // R8
    AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (rst) left_q <= LOAD_V);              // R8
endmodule

// File: rtl/hb_deadband.sv
module hb_deadband
    import hb_gate_pkg::*;
#(
    parameter int DEAD_CYC = 53
) (
    input  logic       clk,
    input  logic       rst,
    input  gate_req_t  req,
    output gate_pair_t gates
);
    localparam int CW = $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] GAP_END = CW'(DEAD_CYC - 1);

    gate_pair_t    g_q;
    logic [CW-1:0] gap_q;
    logic          gap_done;
    logic          idle;

    assign idle     = ~g_q.hi & ~g_q.lo;
    assign gap_done = (gap_q == GAP_END);

    // Gap counter: counts cycles with both off while some side is requested
    always_ff @(posedge clk) begin
        if (rst)                                      gap_q <= '0;
        else if (!idle || !(req.want_hi || req.want_lo)) gap_q <= '0;
        else if (!gap_done)                           gap_q <= gap_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            g_q <= GATES_OFF;
        end else begin
            if (g_q.hi)                               g_q.hi <= req.want_hi;
            else if (idle && req.want_hi && gap_done) g_q.hi <= 1'b1;

            if (g_q.lo)                               g_q.lo <= req.want_lo;
            else if (idle && req.want_lo && gap_done) g_q.lo <= 1'b1;
        end
    end

    assign gates = g_q;

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst) !(g_q.hi && g_q.lo));               // R3
    AST_HI_FOLLOWS: assert property (@(posedge clk) disable iff (rst) g_q.hi |-> $past(req.want_hi));     // R1
    AST_LO_FOLLOWS: assert property (@(posedge clk) disable iff (rst) g_q.lo |-> $past(req.want_lo));     // R1
    AST_HI_FROM_IDLE: assert property (@(posedge clk) disable iff (rst) $rose(g_q.hi) |-> $past(!g_q.lo)); // R2
    AST_LO_FROM_IDLE: assert property (@(posedge clk) disable iff (rst) $rose(g_q.lo) |-> $past(!g_q.hi)); // R2
endmodule

// File: rtl/hb_gate_sequencer.sv
module hb_gate_sequencer
    import hb_gate_pkg::*;
#(
    parameter int DEAD_CYC = 53,
    parameter int HOLD_CYC = 450
) (
    input  logic clk,
    input  logic rst,
    input  logic pwm_in,
    input  logic shdn_n,
    input  logic lo_supply_ok,
    input  logic hi_supply_ok,
    input  logic neg_tr_pulse,
    output logic gate_hi,
    output logic gate_lo
);
    logic [1:0]  sync_q;
    logic        cmd_s;
    logic        run_s;
    logic        hold_busy;
    gate_allow_t allow;
    gate_req_t   req;
    gate_pair_t  gates;

    // bit 1: shutdown (reset to 0 = blocked), bit 0: PWM command
    hb_sync_stage #(.W(2), .STAGES(2), .RST_V(2'b00)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async ({shdn_n, pwm_in}),
        .q_sync  (sync_q)
    );

    assign cmd_s = sync_q[0];
    assign run_s = sync_q[1];

    hb_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .hit  (neg_tr_pulse),
        .busy (hold_busy)
    );

    assign allow = f_allow(run_s, lo_supply_ok, hi_supply_ok, hold_busy);
    assign req   = f_request(cmd_s, allow);

    hb_deadband #(.DEAD_CYC(DEAD_CYC)) u_dead (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .gates (gates)
    );

    assign gate_hi = gates.hi;
    assign gate_lo = gates.lo;

    AST_SHDN_OFF: assert property (@(posedge clk) disable iff (rst) !run_s |=> !gate_hi && !gate_lo);        // R4
    AST_LO_UV:    assert property (@(posedge clk) disable iff (rst) !lo_supply_ok |=> !gate_hi && !gate_lo); // R6
    AST_HI_UV:    assert property (@(posedge clk) disable iff (rst) !hi_supply_ok |=> !gate_hi);             // R7
    AST_HOLD_HI:  assert property (@(posedge clk) disable iff (rst) hold_busy |=> !gate_hi);                 // R8
endmodule

// File: tb/hb_gate_sequencer_tb_top.sv
module hb_gate_sequencer_tb_top;
    localparam int D = 4;
    localparam int H = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwm_in = 1'b0;
    logic shdn_n = 1'b1;
    logic lo_supply_ok = 1'b1;
    logic hi_supply_ok = 1'b1;
    logic neg_tr_pulse = 1'b0;
    logic gate_hi;
    logic gate_lo;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit overlap_seen = 1'b0;

    typedef struct {
        int    at;
        logic  hi;
        logic  lo;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hb_gate_sequencer #(.DEAD_CYC(D), .HOLD_CYC(H)) dut_i (
        .clk(clk), .rst(rst), .pwm_in(pwm_in), .shdn_n(shdn_n),
        .lo_supply_ok(lo_supply_ok), .hi_supply_ok(hi_supply_ok),
        .neg_tr_pulse(neg_tr_pulse), .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    // Driver side: queue an expectation d cycles ahead
    task automatic expect_at(input int d, input logic h, input logic l, input string t);
        exp_t e;
        e.at = cyc + d; e.hi = h; e.lo = l; e.tag = t;
        sb_q.push_back(e);
    endtask

    task automatic step(input int k);
        repeat (k) @(negedge clk);
    endtask

    // Monitor: compare queued expectations at their cycle
    always @(negedge clk) begin
        for (int i = sb_q.size() - 1; i >= 0; i--) begin
            if (sb_q[i].at <= cyc) begin
                n_chk++;
                if (sb_q[i].at != cyc || gate_hi !== sb_q[i].hi || gate_lo !== sb_q[i].lo) begin
                    n_fail++;
                    $display("FAIL %s cyc %0d: actual hi=%b lo=%b, expected hi=%b lo=%b",
                             sb_q[i].tag, cyc, gate_hi, gate_lo, sb_q[i].hi, sb_q[i].lo);
                end
                sb_q.delete(i);
            end
        end
        if (gate_hi === 1'b1 && gate_lo === 1'b1) overlap_seen = 1'b1;
    end

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #2000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
        $finish;
    end

    initial begin
        // R9: reset state and first turn-on after a full break interval
        step(1);
        expect_at(1, 0, 0, "R9");
        step(4);
        rst = 1'b0;
        expect_at(1 + D, 0, 0, "R9");
        expect_at(2 + D, 0, 1, "R9");
        step(D + 8);

        // R10/R2: rising command, low side hands over to high side
        pwm_in = 1'b1;
        expect_at(2, 0, 1, "R10");
        expect_at(3, 0, 0, "R10");
        expect_at(2 + D, 0, 0, "R2");
        expect_at(3 + D, 1, 0, "R2");
        step(D + 8);
        expect_at(1, 1, 0, "R1");
        step(2);

        // R2: falling command, high side hands over to low side
        pwm_in = 1'b0;
        expect_at(2, 1, 0, "R10");
        expect_at(3, 0, 0, "R2");
        expect_at(2 + D, 0, 0, "R2");
        expect_at(3 + D, 0, 1, "R2");
        step(D + 8);
        expect_at(1, 0, 1, "R1");
        step(2);

        // R7: high-side supply bad leaves low side running
        hi_supply_ok = 1'b0;
        expect_at(1, 0, 1, "R7");
        expect_at(4, 0, 1, "R7");
        step(6);
        pwm_in = 1'b1;
        expect_at(3, 0, 0, "R7");
        expect_at(D + 6, 0, 0, "R7");
        step(D + 8);
        hi_supply_ok = 1'b1;
        expect_at(D - 1, 0, 0, "R5");
        expect_at(D, 1, 0, "R5");
        step(D + 4);

        // R6: low-side supply bad forces both off
        lo_supply_ok = 1'b0;
        expect_at(1, 0, 0, "R6");
        expect_at(5, 0, 0, "R6");
        step(6);
        lo_supply_ok = 1'b1;
        expect_at(D - 1, 0, 0, "R5");
        expect_at(D, 1, 0, "R5");
        step(D + 4);

        // R4: shutdown through its synchronizer
        shdn_n = 1'b0;
        expect_at(2, 1, 0, "R4");
        expect_at(3, 0, 0, "R4");
        step(5);
        pwm_in = 1'b0;
        expect_at(3, 0, 0, "R4");
        expect_at(D + 5, 0, 0, "R4");
        step(D + 7);
        shdn_n = 1'b1;
        expect_at(D + 1, 0, 0, "R5");
        expect_at(D + 2, 0, 1, "R5");
        step(D + 5);

        // R8: hold-off after a transient, then reload while it runs
        pwm_in = 1'b1;
        expect_at(D + 3, 1, 0, "R1");
        step(D + 6);
        expect_at(1, 1, 0, "R8");
        expect_at(2, 0, 0, "R8");
        neg_tr_pulse = 1'b1;
        step(1);
        neg_tr_pulse = 1'b0;
        step(9);
        expect_at(H + D - 9, 0, 0, "R8");
        expect_at(H + D, 0, 0, "R8");
        expect_at(H + D + 1, 1, 0, "R8");
        neg_tr_pulse = 1'b1;
        step(1);
        neg_tr_pulse = 1'b0;
        step(H + D + 6);

        // R8: transient leaves the low side alone
        pwm_in = 1'b0;
        step(D + 8);
        expect_at(2, 0, 1, "R8");
        expect_at(6, 0, 1, "R8");
        neg_tr_pulse = 1'b1;
        step(1);
        neg_tr_pulse = 1'b0;
        step(10);

        step(5);
        n_chk++;
        if (overlap_seen) begin
            n_fail++;
            $display("FAIL R3: actual=both enables high seen expected=never");
        end
        if (sb_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL R1: actual=%0d pending expected=0", sb_q.size());
        end
        report();
        $finish;
    end
endmodule